// File: doc/BRIEF.md
# Fine-step center-aligned dual PWM

This block generates two center-aligned pulse trains from one triangular counter. The counter has a 16-bit coarse part extended below by a few fine bits. It advances by one fine step per clock, so pulse edges can be placed at a fraction of a coarse count. It rises from zero to the period value, with the fine bits at zero, and then falls back to zero. The fine bits take part in both directions, so the fall is as exact as the rise.

The host writes a period, two compare values, or a single duty value into shadow registers. A duty write fills both compares at once: the zero-centered channel gets the clamped duty, and the peak-centered channel gets the period minus the clamped duty. The shadow values move into the active registers only when the counter sits at zero, or on a synchronous clear. A change therefore never cuts a pulse in the middle of a cycle. The extended count is brought out so that the phase can be observed.

Top module: `hrCenterPwm`

## Requirements
- R1: After reset `cnt` is 0 and both outputs are low. The shadow period resets to 0, so the counter stays at 0 until a period is written and loaded.
- R2: With active period P and S = 2^FINE_W fine steps per count (S = 8 by default), `cnt` rises by one per clock from 0 to P*S. It then falls by one per clock back to 0, so one PWM cycle lasts 2*P*S clocks.
- R3: In the falling half the whole extended count, fine bits included, decreases by exactly one each clock. This holds across every coarse boundary.
- R4: `pwmZero` goes high on the falling-phase match with compare A and low on the rising-phase match. It is forced low at the peak. With compare A = C it is high for 2*C clocks per cycle, and it is high when `cnt` is 0.
- R5: `pwmPeak` goes high on the rising-phase match with compare B and low on the falling-phase match. It is forced high at the peak. With compare B = D it is high for 2*(P*S - D) clocks per cycle, and it is high when `cnt` is P*S.
- R6: The write select codes are 0 for the period (from the low 16 bits of `wrData`), 1 for compare A, 2 for compare B and 3 for duty. A duty write of d sets compare A to clamp(d) and compare B to P_shadow*S - clamp(d). The two compares therefore give pulses of equal width and become active in the same load.
- R7: The duty value is clamped to the range [DUTY_MIN, DUTY_MAX], which defaults to [3, 20] fine steps.
- R8: Shadow writes do not change the active period or compares until the counter is at 0. A write made mid-cycle leaves the rest of that cycle unchanged.
- R9: A `syncClr` pulse sets `cnt` to 0 at the next edge, sets the direction to rising, loads the shadow registers at once, and drives both outputs low.
- R10: When the period loaded at zero is 0, `cnt` stays at 0 and both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine-step clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncClr | input | 1 | Synchronous clear and immediate shadow load |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 period, 1 compare A, 2 compare B, 3 duty |
| wrData | input | CNT_W+FINE_W | Write value in fine steps (period uses low CNT_W bits) |
| pwmZero | output | 1 | Pulse centered on count zero |
| pwmPeak | output | 1 | Pulse centered on the period peak |
| cnt | output | CNT_W+FINE_W | Extended triangular count |

## Verification
A table of period and duty pairs drives the main function. It includes a mid-range duty, duties below the minimum and above the maximum, duties exactly at each clamp limit, and three different periods. In the second full cycle after each load, the count trace is compared step by step with the ideal triangle. Any fine bit that keeps rising while the coarse part falls breaks that comparison. The pulse widths and their centers show whether the compares were placed and clamped correctly. Directed runs then change the duty and the period mid-cycle, which separates deferred loading from immediate loading. They also clear the block while a pulse is high and load a zero period.

// File: rtl/hrPwmPkg.sv
package hrPwmPkg;

  // Strobes from the control into the datapath, one set per clock
  typedef struct packed {
    logic clear;      // synchronous clear
    logic load;       // shadow -> active transfer
    logic idle;       // loaded period is zero: hold counter, outputs low
    logic countUp;    // advance extended count by one
    logic countDown;  // retreat extended count by one
  } pwmStrobe_t;

  typedef enum logic [1:0] {
    SEL_PERIOD   = 2'd0,
    SEL_CMP_ZERO = 2'd1,
    SEL_CMP_PEAK = 2'd2,
    SEL_DUTY     = 2'd3
  } regSel_e;

endpackage

// File: rtl/hrPwmCtrl.sv
module hrPwmCtrl
  import hrPwmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncClr,
  input  logic       atZero,
  input  logic       atPeak,
  input  logic       nextPeriodZero,
  output pwmStrobe_t strb
);

  logic dirDown;

  always_comb begin
    strb       = '0;
    strb.clear = syncClr;
    strb.load  = syncClr | atZero;
    if (!syncClr) begin
      if (atZero) begin
        strb.idle    = nextPeriodZero;
        strb.countUp = !nextPeriodZero;
      end else if (atPeak || dirDown) begin
        strb.countDown = 1'b1;
      end else begin
        strb.countUp = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dirDown <= 1'b0;
    else if (syncClr || atZero) dirDown <= 1'b0;
    else if (atPeak)           dirDown <= 1'b1;
  end

  // R2: never step both ways at once
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.countUp, strb.countDown}));

  // R2: reaching the peak turns the counter downward
  a_r2_turn_down: assert property (@(posedge clk) disable iff (!rstN)
    (atPeak && !syncClr) |=> dirDown);

endmodule

// File: rtl/hrPwmDatapath.sv
module hrPwmDatapath
  import hrPwmPkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned FINE_W   = 3,
  parameter int unsigned DUTY_MIN = 3,
  parameter int unsigned DUTY_MAX = 20,
  localparam int unsigned EXT_W   = CNT_W + FINE_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strb,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [EXT_W-1:0] wrData,
  output logic [EXT_W-1:0] cnt,
  output logic             atZero,
  output logic             atPeak,
  output logic             nextPeriodZero,
  output logic             pwmZero,
  output logic             pwmPeak
);

  localparam logic [EXT_W-1:0] MIN_EXT = EXT_W'(DUTY_MIN);
  localparam logic [EXT_W-1:0] MAX_EXT = EXT_W'(DUTY_MAX);

  logic [CNT_W-1:0] shPeriod, actPeriod;
  logic [EXT_W-1:0] shCmpZero, shCmpPeak, actCmpZero, actCmpPeak;
  logic [EXT_W-1:0] dutyClamped, peakExt, shPeakExt;
  logic             hitZero, hitPeak;

  assign dutyClamped = (wrData < MIN_EXT) ? MIN_EXT :
                       (wrData > MAX_EXT) ? MAX_EXT : wrData;
  assign shPeakExt   = {shPeriod, {FINE_W{1'b0}}};
  assign peakExt     = {actPeriod, {FINE_W{1'b0}}};

  // Shadow registers written by the host
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPeriod  <= '0;
      shCmpZero <= '0;
      shCmpPeak <= '0;
    end else if (wrEn) begin
      case (regSel_e'(wrSel))
        SEL_PERIOD:   shPeriod  <= wrData[CNT_W-1:0];
        SEL_CMP_ZERO: shCmpZero <= wrData;
        SEL_CMP_PEAK: shCmpPeak <= wrData;
        default: begin
          shCmpZero <= dutyClamped;
          shCmpPeak <= shPeakExt - dutyClamped;
        end
      endcase
    end
  end

  // Active registers: only move on a load strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPeriod  <= '0;
      actCmpZero <= '0;
      actCmpPeak <= '0;
    end else if (strb.load) begin
      actPeriod  <= shPeriod;
      actCmpZero <= shCmpZero;
      actCmpPeak <= shCmpPeak;
    end
  end

  // Extended counter: coarse and fine bits move together in both directions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strb.clear)     cnt <= '0;
    else if (strb.countUp)   cnt <= cnt + 1'b1;
    else if (strb.countDown) cnt <= cnt - 1'b1;
  end

  assign atZero         = (cnt == '0);
  assign atPeak         = (actPeriod != '0) && (cnt == peakExt);
  assign nextPeriodZero = (shPeriod == '0);
  assign hitZero        = (cnt == actCmpZero);
  assign hitPeak        = (cnt == actCmpPeak);

  // Phase-qualified set/clear outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmZero <= 1'b0;
      pwmPeak <= 1'b0;
    end else if (strb.clear || strb.idle) begin
      pwmZero <= 1'b0;
      pwmPeak <= 1'b0;
    end else begin
      if (atPeak)       pwmZero <= 1'b0;
      else if (hitZero) pwmZero <= strb.countDown;
      if (atPeak)       pwmPeak <= 1'b1;
      else if (hitPeak) pwmPeak <= !strb.countDown;
    end
  end

  // R3: every falling step takes exactly one fine step off the full count
  a_r3_down_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.countDown |=> cnt == $past(cnt) - 1'b1);

  // R4 and R5: levels at the peak
  a_r4_peak_levels: assert property (@(posedge clk) disable iff (!rstN)
    (atPeak && !strb.clear) |=> (!pwmZero && pwmPeak));

  // R7: a duty write always leaves a clamped compare
  a_r7_clamped: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd3) |=> (shCmpZero >= MIN_EXT && shCmpZero <= MAX_EXT));

  // R8: active values only change on a load
  a_r8_hold_active: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(actPeriod) && $stable(actCmpZero) && $stable(actCmpPeak)));

  // R10: zero period keeps everything parked
  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> (cnt == '0 && !pwmZero && !pwmPeak));

endmodule

// File: rtl/hrCenterPwm.sv
module hrCenterPwm
  import hrPwmPkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned FINE_W   = 3,
  parameter int unsigned DUTY_MIN = 3,
  parameter int unsigned DUTY_MAX = 20,
  localparam int unsigned EXT_W   = CNT_W + FINE_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncClr,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [EXT_W-1:0] wrData,
  output logic             pwmZero,
  output logic             pwmPeak,
  output logic [EXT_W-1:0] cnt
);

  pwmStrobe_t strb;
  logic       atZero, atPeak, nextPeriodZero;

  hrPwmCtrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .syncClr        (syncClr),
    .atZero         (atZero),
    .atPeak         (atPeak),
    .nextPeriodZero (nextPeriodZero),
    .strb           (strb)
  );

  hrPwmDatapath #(
    .CNT_W    (CNT_W),
    .FINE_W   (FINE_W),
    .DUTY_MIN (DUTY_MIN),
    .DUTY_MAX (DUTY_MAX)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .wrEn           (wrEn),
    .wrSel          (wrSel),
    .wrData         (wrData),
    .cnt            (cnt),
    .atZero         (atZero),
    .atPeak         (atPeak),
    .nextPeriodZero (nextPeriodZero),
    .pwmZero        (pwmZero),
    .pwmPeak        (pwmPeak)
  );

  // R9: clear parks the counter and the outputs on the next edge
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    syncClr |=> (cnt == '0 && !pwmZero && !pwmPeak));

endmodule

// File: tb/hrCenterPwm_test.sv
module hrCenterPwm_test;

  localparam int EW = 19;
  localparam int FS = 8;
  localparam int NV = 7;
  // period, duty written, expected pulse width (2*clamp(duty), clamp [3,20])
  localparam int VEC [NV][3] = '{
    '{4, 10, 20}, '{4, 1, 6}, '{4, 30, 40}, '{6, 17, 34},
    '{3, 5, 10},  '{4, 20, 40}, '{4, 3, 6}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          syncClr = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = 2'd0;
  logic [EW-1:0] wrData = '0;
  logic          pwmZero, pwmPeak;
  logic [EW-1:0] cnt;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  int k, errs, w1, w2, ps;
  logic mid1, pk2;

  always #2 clk = ~clk;

  hrCenterPwm uut (
    .clk(clk), .rstN(rstN), .syncClr(syncClr), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData),
    .pwmZero(pwmZero), .pwmPeak(pwmPeak), .cnt(cnt)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    k++;
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    wrEn = 1'b1; wrSel = sel; wrData = EW'(data);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic clearPulse();
    syncClr = 1'b1;
    tick();
    syncClr = 1'b0;
    k = 0;
  endtask

  function automatic int triExp(input int kk, input int pp);
    int pos;
    pos = kk % (2 * pp);
    return (pos <= pp) ? pos : 2 * pp - pos;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    k = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cnt == 0 && !pwmZero && !pwmPeak, "R1 reset", cnt, 0);
    rstN = 1'b1;
    repeat (10) tick();
    check(cnt == 0 && !pwmZero && !pwmPeak, "R1 no period loaded", cnt, 0);

    // Table walk: R2 R3 trace, R4 R5 widths/centers, R6 R7 duty mapping and clamp
    for (int v = 0; v < NV; v++) begin
      ps = VEC[v][0] * FS;
      wr(2'd0, VEC[v][0]);
      wr(2'd3, VEC[v][1]);
      clearPulse();
      errs = 0; w1 = 0; w2 = 0; mid1 = 1'b0; pk2 = 1'b0;
      for (int j = 0; j < 4 * ps; j++) begin
        if (int'(cnt) != triExp(j, ps)) errs++;
        if (j >= 2 * ps) begin
          w1 += int'(pwmZero);
          w2 += int'(pwmPeak);
          if (j == 2 * ps) mid1 = pwmZero;
          if (j == 3 * ps) pk2 = pwmPeak;
        end
        tick();
      end
      check(errs == 0, "R2 R3 triangle trace", errs, 0);
      check(w1 == VEC[v][2], "R4 R7 zero-centered width", w1, VEC[v][2]);
      check(w2 == VEC[v][2], "R5 R6 peak-centered width", w2, VEC[v][2]);
      check(mid1 == 1'b1, "R4 high at zero", mid1, 1);
      check(pk2 == 1'b1, "R5 high at peak", pk2, 1);
    end

    // R8: duty change mid-cycle, P=4 (peak 32), duty 10 -> 6
    wr(2'd0, 4); wr(2'd3, 10); clearPulse();
    while (k < 80) tick();
    wr(2'd3, 6);
    while (k < 119) tick();
    check(pwmZero == 1'b1, "R8 old duty kept this cycle", pwmZero, 1);
    while (k < 134) tick();
    check(pwmZero == 1'b1, "R8 new duty high at 6", pwmZero, 1);
    tick();
    check(pwmZero == 1'b0, "R8 new duty low at 7", pwmZero, 0);
    while (k < 183) tick();
    check(pwmZero == 1'b0, "R8 new duty low at falling 9", pwmZero, 0);

    // R8: period change mid-cycle, 4 -> 6
    wr(2'd0, 4); wr(2'd3, 10); clearPulse();
    while (k < 8) tick();
    wr(2'd0, 6);
    while (k < 32) tick();
    check(cnt == 32, "R8 old peak kept", cnt, 32);
    tick();
    check(cnt == 31, "R8 old peak turnaround", cnt, 31);
    while (k < 112) tick();
    check(cnt == 48, "R8 new peak after load", cnt, 48);
    check(pwmPeak == 1'b1, "R5 peak output before clear", pwmPeak, 1);

    // R9: clear while running
    syncClr = 1'b1;
    tick();
    syncClr = 1'b0;
    check(cnt == 0 && !pwmZero && !pwmPeak, "R9 clear parks", cnt, 0);
    tick();
    check(cnt == 1, "R9 rising after clear", cnt, 1);

    // R10: zero period
    wr(2'd0, 0);
    repeat (100) tick();
    errs = 0;
    for (int j = 0; j < 20; j++) begin
      if (cnt != 0 || pwmZero || pwmPeak) errs++;
      tick();
    end
    check(errs == 0, "R10 zero period holds", errs, 0);

    finishRun();
  end

endmodule